// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a small status byte that tells software why the chip last came out of reset. Four reset sources report to it through single-cycle strobes: power-on, brown-out, watchdog and the external reset pin. Each strobe sets its own flag in the byte. The flags stay set through later resets from any source other than power-on, so firmware can read the byte early after boot and learn the cause.

A power-on strobe is the only event that reinitialises the register. It leaves just the power-on flag set. Software reaches the register through a simple bus port that has an address, a write enable, write data and combinational read data. Writing a zero to a flag bit clears that flag. Writing a one leaves the bit as it was, so software can never set a flag. The upper four bits are unused: they always read as zero and ignore writes.

Top module: `rstcause_reg`

## Requirements
- R1: In the cycle after a power-on strobe, the register reads 0x01. This holds even when the other strobes are active in the same cycle.
- R2: A watchdog strobe sets bit 3. A brown-out strobe sets bit 2. An external strobe sets bit 1. The register is read at bus address 0x54.
- R3: A watchdog, brown-out or external strobe leaves every other flag unchanged.
- R4: A write to 0x54 clears each of bits 3..0 whose write-data bit is 0. It leaves unchanged each bit whose write-data bit is 1.
- R5: Bit 0 (power-on) is cleared only by a software write of 0. Watchdog, brown-out and external strobes do not change it.
- R6: Bits 7..4 always read as 0, including after writes of 1 to those positions.
- R7: When a strobe and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R8: A write to any address other than 0x54 changes nothing. A read at any other address returns 0x00.
- R9: Read data is combinational. It shows the register contents in the same cycle the address is presented, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_evt | input | 1 | Power-on reset strobe, one cycle; the register's only true reset |
| bor_evt | input | 1 | Brown-out reset strobe, one cycle |
| wdt_evt | input | 1 | Watchdog reset strobe, one cycle |
| ext_evt | input | 1 | External reset strobe, one cycle |
| bus_addr | input | 8 | Bus address; the register decodes 0x54 |
| bus_we | input | 1 | Bus write enable |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data, combinational |

## Verification
A wrong flag shows up on bus_rdata at the first read of 0x54 after the clock edge that stored it. One cycle after any strobe or write is therefore enough to see it. The faults that stay hidden longest are the ones that leave a flag alone when it should change: a strobe that clears a neighbour, a write of 1 that clears, or a power-on flag lost to another reset source. The bench therefore reads the whole byte after every step, so that no cleared neighbour goes unnoticed. It also drives strobes and writes into the same cycle to expose priority errors.

// File: rtl/rcause_pkg.sv
package rcause_pkg;

    localparam int DATA_W  = 8;
    localparam int NUM_SRC = 4;

    // Bit positions software decodes; these order the flags in the byte
    localparam int IDX_POR = 0;
    localparam int IDX_EXT = 1;
    localparam int IDX_BOR = 2;
    localparam int IDX_WDT = 3;

    typedef struct packed {
        logic wdt;
        logic bor;
        logic ext;
        logic por;
    } cause_vec_t;

endpackage

// File: rtl/rcause_flag.sv
module rcause_flag #(
    parameter bit CLR_ON_POR = 1'b1
) (
    input  logic clk,
    input  logic por_evt,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag
);

    typedef struct packed {
        logic val;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (CLR_ON_POR && por_evt) begin
            st_d.val = 1'b0;
        end else if (set_evt) begin
            st_d.val = 1'b1;          // event beats a same-cycle clear
        end else if (clr_req) begin
            st_d.val = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign flag = st_q.val;

endmodule

// File: rtl/rcause_decode.sv
module rcause_decode
    import rcause_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h54
) (
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [NUM_SRC-1:0] flags,
    output logic [NUM_SRC-1:0] clr_req,
    output logic [DATA_W-1:0]  bus_rdata
);

    localparam int PAD_W = DATA_W - NUM_SRC;

    logic sel;
    assign sel = (bus_addr == REG_ADDR);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
        assign clr_req[i] = sel & bus_we & ~bus_wdata[i];
    end

    always_comb begin
        bus_rdata = '0;
        if (sel) begin
            bus_rdata = {{PAD_W{1'b0}}, flags};
        end
    end

    always_comb begin
        assert (bus_rdata[DATA_W-1:NUM_SRC] == '0)
            else $error("reserved bits nonzero");   // assert_reserved_zero_R6
    end

endmodule

// File: rtl/rstcause_reg.sv
module rstcause_reg
    import rcause_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h54
) (
    input  logic              clk,
    input  logic              por_evt,
    input  logic              bor_evt,
    input  logic              wdt_evt,
    input  logic              ext_evt,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    cause_vec_t         evt_d;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] flags_q;

    always_comb begin
        evt_d.por = por_evt;
        evt_d.ext = ext_evt;
        evt_d.bor = bor_evt;
        evt_d.wdt = wdt_evt;
        set_vec   = evt_d;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        rcause_flag #(
            .CLR_ON_POR(i != IDX_POR)
        ) u_flag (
            .clk    (clk),
            .por_evt(por_evt),
            .set_evt(set_vec[i]),
            .clr_req(clr_vec[i]),
            .flag   (flags_q[i])
        );
    end

    rcause_decode #(
        .ADDR_W  (ADDR_W),
        .REG_ADDR(REG_ADDR)
    ) u_dec (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .flags    (flags_q),
        .clr_req  (clr_vec),
        .bus_rdata(bus_rdata)
    );

    logic hit_wr;
    assign hit_wr = bus_we && (bus_addr == REG_ADDR);

    assert_por_value_R1: assert property (@(posedge clk)
        por_evt |=> (flags_q == 4'b0001));

    assert_wdt_sets_R2: assert property (@(posedge clk) disable iff (por_evt)
        wdt_evt |=> flags_q[IDX_WDT]);

    assert_quiet_stable_R3: assert property (@(posedge clk) disable iff (por_evt)
        (!bor_evt && !wdt_evt && !ext_evt && !hit_wr) |=> $stable(flags_q));

    assert_write_clears_R4: assert property (@(posedge clk) disable iff (por_evt)
        (hit_wr && !bus_wdata[IDX_BOR] && !bor_evt) |=> !flags_q[IDX_BOR]);

    assert_por_flag_kept_R5: assert property (@(posedge clk) disable iff (por_evt)
        !(hit_wr && !bus_wdata[IDX_POR]) |=> $stable(flags_q[IDX_POR]));

    assert_event_wins_R7: assert property (@(posedge clk) disable iff (por_evt)
        (ext_evt && hit_wr && !bus_wdata[IDX_EXT]) |=> flags_q[IDX_EXT]);

endmodule

// File: tb/rstcause_reg_test.sv
`timescale 1ns/1ps
module rstcause_reg_test;

    localparam logic [7:0] RADDR = 8'h54;

    logic       clk = 1'b0;
    logic       por_evt = 1'b1;
    logic       bor_evt = 1'b0;
    logic       wdt_evt = 1'b0;
    logic       ext_evt = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rstcause_reg uut (
        .clk(clk), .por_evt(por_evt), .bor_evt(bor_evt), .wdt_evt(wdt_evt),
        .ext_evt(ext_evt), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // One clock with the given strobes {wdt,bor,ext,por} and optional write
    task automatic step(input logic [3:0] ev, input logic we,
                        input logic [7:0] addr, input logic [7:0] wd);
        @(negedge clk);
        {wdt_evt, bor_evt, ext_evt, por_evt} = ev;
        bus_we = we; bus_addr = addr; bus_wdata = wd;
        @(negedge clk);
        {wdt_evt, bor_evt, ext_evt, por_evt} = 4'b0;
        bus_we = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic check_at(input logic [7:0] addr, input logic [7:0] exp,
                            input string req);
        bus_addr = addr;
        #1;
        n_chk++;
        if (bus_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s: read 0x%02h got 0x%02h expected 0x%02h",
                     req, addr, bus_rdata, exp);
        end
    endtask

    task automatic t_reset;                       // R1
        step(4'b0001, 1'b0, RADDR, 8'h00);
        check_at(RADDR, 8'h01, "R1");
    endtask

    task automatic t_events;                      // R2 R3 R5
        step(4'b0010, 1'b0, RADDR, 8'h00);
        check_at(RADDR, 8'h03, "R2");
        step(4'b0100, 1'b0, RADDR, 8'h00);
        check_at(RADDR, 8'h07, "R3");
        step(4'b1000, 1'b0, RADDR, 8'h00);
        check_at(RADDR, 8'h0F, "R5");
    endtask

    task automatic t_clear;                       // R4 R5
        step(4'b0000, 1'b1, RADDR, 8'hF7);
        check_at(RADDR, 8'h07, "R4");
        step(4'b0000, 1'b1, RADDR, 8'hFF);
        check_at(RADDR, 8'h07, "R4");
        step(4'b0000, 1'b1, RADDR, 8'hFE);
        check_at(RADDR, 8'h06, "R5");
        step(4'b0000, 1'b1, RADDR, 8'h00);
        check_at(RADDR, 8'h00, "R4");
    endtask

    task automatic t_reserved;                    // R6
        step(4'b0010, 1'b0, RADDR, 8'h00);
        step(4'b0000, 1'b1, RADDR, 8'hF2);
        check_at(RADDR, 8'h02, "R6");
    endtask

    task automatic t_other_addr;                  // R8
        step(4'b0000, 1'b1, 8'h55, 8'h00);
        check_at(RADDR, 8'h02, "R8");
        check_at(8'h34, 8'h00, "R8");
    endtask

    task automatic t_collision;                   // R7
        step(4'b0100, 1'b1, RADDR, 8'h00);
        check_at(RADDR, 8'h04, "R7");
    endtask

    task automatic t_por_mix;                     // R1 R9
        step(4'b1000, 1'b0, RADDR, 8'h00);
        check_at(8'h00, 8'h00, "R9");
        check_at(RADDR, 8'h0C, "R9");
        step(4'b1111, 1'b0, RADDR, 8'h00);
        check_at(RADDR, 8'h01, "R1");
    endtask

    initial begin
        repeat (2) @(negedge clk);
        por_evt = 1'b0;
        t_reset();
        t_events();
        t_clear();
        t_reserved();
        t_other_addr();
        t_collision();
        t_por_mix();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule